// File: doc/BRIEF.md
# Pseudo-static RAM refresh engine

This block models the refresh control that sits inside a pseudo-static RAM. It decides, on every clock, whether the memory array is touched for an external read or write, for a refresh of a row the host names, for a single refresh that the host requests with the refresh strobe, or for a run of refreshes that an internal timer paces while the refresh strobe is held low. Internally addressed refreshes take their row from a counter that steps once per refresh. The other cycles take the row from the external row address bits.

The control strobes are all active low and are sampled on the rising clock edge. The block drives the row address to the array and a row-activate level that stands in for the array, sense amplifiers and I/O. It also drives a busy level that is high whenever a refresh owns the array, so that the surrounding logic can spot an external access that starts at the wrong time. All durations are counted in clock cycles: activation, precharge, the delay between chip enable rising and a refresh start, the low time that leads to self-refresh, the self-refresh interval and the recovery time after self-refresh.

Top module: `psram_refresh_engine`

## Requirements
- R1: After reset, row_act and busy are low, row_addr is 0 and the internal row counter is 0.
- R2: When ce_n has been high for at least RFD_CYC sampled cycles and the engine is idle, the first low sample of rfsh_n after a high one starts an internal refresh. row_act is high for ACT_CYC cycles starting on the edge of that sample. busy is high from that edge until the PRE_CYC precharge cycles that follow have ended.
- R3: The internal row counter is ROW_W (9) bits wide and holds the row for the next internal refresh. It steps by one after every auto or self refresh, wraps from 511 to 0, and is not touched by any other cycle.
- R4: A ce_n fall sampled while idle with cs_n high is a chip-enable-only refresh. It activates the row on ext_row with busy high.
- R5: A ce_n fall sampled while idle with cs_n low is an external access. It activates the row on ext_row with busy low.
- R6: A low pulse on rfsh_n that begins and ends while ce_n is low starts no activation.
- R7: A refresh request made fewer than RFD_CYC cycles after ce_n rises is held back. It starts on the edge after the RFD_CYC-th high sample of ce_n.
- R8: After SELF_THRESH consecutive low samples of rfsh_n with ce_n high, the engine enters self-refresh and holds busy high. Starting SELF_PERIOD cycles after entry, it makes one internal refresh every SELF_PERIOD cycles.
- R9: A high sample of rfsh_n ends self-refresh. Once any refresh in progress is over, busy stays high for RECOV_CYC more cycles. A timer expiry that falls on the exit edge produces no refresh.
- R10: A ce_n fall sampled while an activation, precharge or recovery is in progress is ignored and causes no later activation.
- R11: row_addr is constant for as long as row_act is high.
- R12: One low period of rfsh_n that is shorter than SELF_THRESH cycles produces exactly one refresh, whatever its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_n | input | 1 | Chip enable, active low, sampled |
| cs_n | input | 1 | Chip select, active low. When high at a ce_n fall, the cycle is a refresh only |
| rfsh_n | input | 1 | Refresh strobe, active low. A pulse gives one refresh; a long hold gives self-refresh |
| ext_row | input | ROW_W | Row bits of the external address |
| row_addr | output | ROW_W | Row address presented to the array |
| row_act | output | 1 | High while a row is active |
| busy | output | 1 | High while a refresh, self-refresh or recovery owns the array |

## Verification
Two functions can fall on the same edge: the expiry of the self-refresh timer and the rising edge of rfsh_n that ends self-refresh. The bench holds rfsh_n low for exactly the number of cycles that makes its release coincide with the first timer expiry, and expects only the initial auto refresh plus a recovery window on busy. A second run releases rfsh_n one cycle later, where the expiry must win and give a second refresh. A third overlap, a ce_n fall during an auto refresh, is provoked to confirm that it is dropped. Random sequences of refresh pulses, chip-enable-only cycles and accesses are checked against a row counter that the bench keeps on its own.

// File: rtl/psre_pkg.sv
package psre_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ACT   = 2'd1,
    SQ_PRE   = 2'd2,
    SQ_RECOV = 2'd3
  } sq_state_t;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/psre_row_ctr.sv
module psre_row_ctr #(
  parameter int unsigned ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [ROW_W-1:0] ptr
);

  logic [ROW_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (ptr == $past(ptr) + 1'b1)); // R3
  AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr)); // R3

endmodule

// File: rtl/psre_req_ctl.sv
module psre_req_ctl #(
  parameter int unsigned RFD_CYC     = 4,
  parameter int unsigned SELF_THRESH = 800,
  parameter int unsigned SELF_PERIOD = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic rfsh_n,
  input  logic auto_taken,
  output logic auto_req,
  output logic self_mode,
  output logic self_tick,
  output logic self_exit
);

  localparam int unsigned RW = $clog2(RFD_CYC + 1);
  localparam int unsigned LW = $clog2(SELF_THRESH + 1);
  localparam int unsigned PW = $clog2(SELF_PERIOD + 1);

  logic [RW-1:0] rfd_q, rfd_d;
  logic [LW-1:0] lo_q, lo_d;
  logic [PW-1:0] per_q, per_d;
  logic          armed_q, armed_d;
  logic          self_q, self_d;
  logic          rfd_ok, enter;

  always_comb begin
    rfd_ok = (rfd_q == RW'(RFD_CYC));
    rfd_d  = '0;
    if (ce_n) rfd_d = rfd_ok ? rfd_q : rfd_q + 1'b1;

    armed_d = armed_q;
    if (rfsh_n)          armed_d = 1'b1;
    else if (auto_taken) armed_d = 1'b0;

    auto_req = armed_q & ~rfsh_n & ce_n & rfd_ok & ~self_q;

    enter = ~self_q & ~rfsh_n & ce_n & (lo_q == LW'(SELF_THRESH - 1));
    lo_d  = '0;
    if (~self_q & ~rfsh_n & ce_n & ~enter) lo_d = lo_q + 1'b1;

    self_exit = self_q & rfsh_n;
    self_tick = self_q & ~rfsh_n & (per_q == PW'(SELF_PERIOD - 1));
    per_d     = '0;
    if (self_q & ~self_tick & ~self_exit) per_d = per_q + 1'b1;

    self_d = self_q;
    if (enter)          self_d = 1'b1;
    else if (self_exit) self_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rfd_q   <= '0;
      lo_q    <= '0;
      per_q   <= '0;
      armed_q <= 1'b0;
      self_q  <= 1'b0;
    end else begin
      rfd_q   <= rfd_d;
      lo_q    <= lo_d;
      per_q   <= per_d;
      armed_q <= armed_d;
      self_q  <= self_d;
    end
  end

  assign self_mode = self_q;

  AST_SELF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(self_q) |-> ($past(lo_q) == LW'(SELF_THRESH - 1))); // R8

endmodule

// File: rtl/psre_seq.sv
module psre_seq
  import psre_pkg::*;
#(
  parameter int unsigned ROW_W     = 9,
  parameter int unsigned ACT_CYC   = 3,
  parameter int unsigned PRE_CYC   = 2,
  parameter int unsigned RECOV_CYC = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cs_n,
  input  logic [ROW_W-1:0] ext_row,
  input  logic [ROW_W-1:0] ctr_row,
  input  logic             auto_req,
  input  logic             self_mode,
  input  logic             self_tick,
  input  logic             self_exit,
  output logic [ROW_W-1:0] row_addr,
  output logic             row_act,
  output logic             busy,
  output logic             auto_taken,
  output logic             ctr_adv
);

  localparam int unsigned MAXC = max3(ACT_CYC, PRE_CYC, RECOV_CYC);
  localparam int unsigned CW   = $clog2(MAXC + 1);

  sq_state_t        state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             refk_q, refk_d;
  logic             ce_prev_q;
  logic             selfp_q, selfp_d;
  logic             recovp_q, recovp_d;
  logic             idle, ce_fall, go_ext, go_rec, go_self, go_auto, int_go;

  always_comb begin
    idle    = (state_q == SQ_IDLE);
    ce_fall = ce_prev_q & ~ce_n;
    go_ext  = idle & ce_fall;
    go_rec  = idle & ~go_ext & (recovp_q | self_exit);
    go_self = idle & ~go_ext & ~go_rec & (selfp_q | self_tick);
    go_auto = idle & ~go_ext & ~go_rec & ~go_self & auto_req;
    int_go  = go_self | go_auto;

    auto_taken = go_auto;
    ctr_adv    = int_go;

    selfp_d  = ~self_exit & ~go_self & (selfp_q | self_tick);
    recovp_d = ~go_rec & (recovp_q | self_exit);

    state_d = state_q;
    cnt_d   = cnt_q;
    row_d   = row_q;
    refk_d  = refk_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (go_ext | int_go) begin
          state_d = SQ_ACT;
          cnt_d   = '0;
          row_d   = int_go ? ctr_row : ext_row;
          refk_d  = int_go | cs_n;
        end else if (go_rec) begin
          state_d = SQ_RECOV;
          cnt_d   = '0;
        end
      end
      SQ_ACT: begin
        if (cnt_q == CW'(ACT_CYC - 1)) begin
          state_d = SQ_PRE;
          cnt_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      SQ_PRE: begin
        if (cnt_q == CW'(PRE_CYC - 1)) begin
          state_d = SQ_IDLE;
          cnt_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      SQ_RECOV: begin
        if (cnt_q == CW'(RECOV_CYC - 1)) begin
          state_d = SQ_IDLE;
          cnt_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      default: state_d = SQ_IDLE;
    endcase

    busy = (((state_q == SQ_ACT) | (state_q == SQ_PRE)) & refk_q)
         | self_mode | (state_q == SQ_RECOV) | recovp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      cnt_q     <= '0;
      row_q     <= '0;
      refk_q    <= 1'b0;
      ce_prev_q <= 1'b1;
      selfp_q   <= 1'b0;
      recovp_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      row_q     <= row_d;
      refk_q    <= refk_d;
      ce_prev_q <= ce_n;
      selfp_q   <= selfp_d;
      recovp_q  <= recovp_d;
    end
  end

  assign row_addr = row_q;
  assign row_act  = (state_q == SQ_ACT);

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (row_act && $past(row_act)) |-> $stable(row_addr)); // R11
  AST_CE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_fall && !idle) |=> !$rose(row_act)); // R10
  AST_EXIT_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
    self_exit |=> busy); // R9

endmodule

// File: rtl/psram_refresh_engine.sv
module psram_refresh_engine #(
  parameter int unsigned ROW_W       = 9,
  parameter int unsigned ACT_CYC     = 3,
  parameter int unsigned PRE_CYC     = 2,
  parameter int unsigned RFD_CYC     = 4,
  parameter int unsigned SELF_THRESH = 800,
  parameter int unsigned SELF_PERIOD = 1562,
  parameter int unsigned RECOV_CYC   = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cs_n,
  input  logic             rfsh_n,
  input  logic [ROW_W-1:0] ext_row,
  output logic [ROW_W-1:0] row_addr,
  output logic             row_act,
  output logic             busy
);

  logic [ROW_W-1:0] ctr_row;
  logic             auto_req, auto_taken, ctr_adv;
  logic             self_mode, self_tick, self_exit;

  psre_req_ctl #(
    .RFD_CYC    (RFD_CYC),
    .SELF_THRESH(SELF_THRESH),
    .SELF_PERIOD(SELF_PERIOD)
  ) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .rfsh_n    (rfsh_n),
    .auto_taken(auto_taken),
    .auto_req  (auto_req),
    .self_mode (self_mode),
    .self_tick (self_tick),
    .self_exit (self_exit)
  );

  psre_row_ctr #(.ROW_W(ROW_W)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (ctr_adv),
    .ptr  (ctr_row)
  );

  psre_seq #(
    .ROW_W    (ROW_W),
    .ACT_CYC  (ACT_CYC),
    .PRE_CYC  (PRE_CYC),
    .RECOV_CYC(RECOV_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .cs_n      (cs_n),
    .ext_row   (ext_row),
    .ctr_row   (ctr_row),
    .auto_req  (auto_req),
    .self_mode (self_mode),
    .self_tick (self_tick),
    .self_exit (self_exit),
    .row_addr  (row_addr),
    .row_act   (row_act),
    .busy      (busy),
    .auto_taken(auto_taken),
    .ctr_adv   (ctr_adv)
  );

endmodule

// File: tb/test_psram_refresh_engine.sv
module test_psram_refresh_engine;

  localparam int ROW_W = 9;
  localparam int A     = 3;
  localparam int PR    = 2;
  localparam int RFD   = 4;
  localparam int T     = 800;
  localparam int P     = 1562;
  localparam int RC    = 19;

  logic             clk, rst_n, ce_n, cs_n, rfsh_n;
  logic [ROW_W-1:0] ext_row, row_addr;
  logic             row_act, busy;

  psram_refresh_engine #(
    .ROW_W(ROW_W), .ACT_CYC(A), .PRE_CYC(PR), .RFD_CYC(RFD),
    .SELF_THRESH(T), .SELF_PERIOD(P), .RECOV_CYC(RC)
  ) i_psram_refresh_engine (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cs_n(cs_n), .rfsh_n(rfsh_n),
    .ext_row(ext_row), .row_addr(row_addr), .row_act(row_act), .busy(busy)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int act_cnt = 0;
  int hi_cnt  = 0;
  int cyc     = 0;
  int rise_cyc = 0;
  int prev_rise_cyc = 0;
  int exp_ctr = 0;
  int seed_v;
  bit act_prev = 0;
  bit done = 0;
  logic [ROW_W-1:0] act_addr;
  logic             act_busy;

  initial clk = 0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (row_act && !act_prev) begin
        act_cnt       = act_cnt + 1;
        act_addr      = row_addr;
        act_busy      = busy;
        prev_rise_cyc = rise_cyc;
        rise_cyc      = cyc;
      end
      if (row_act) hi_cnt = hi_cnt + 1;
      act_prev = row_act;
    end
  end

  function automatic int next_row(int r);
    return (r + 1) % (1 << ROW_W);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic auto_op(int w);
    int base;
    base = act_cnt;
    rfsh_n = 0;
    wait_n(w);
    rfsh_n = 1;
    wait_n(A + PR + 2);
    chk(act_cnt == base + 1, "R12 one refresh per pulse", act_cnt - base, 1);
    chk(int'(act_addr) == exp_ctr, "R3 counter row", int'(act_addr), exp_ctr);
    chk(act_busy == 1'b1, "R2 busy at refresh", int'(act_busy), 1);
    exp_ctr = next_row(exp_ctr);
  endtask

  task automatic ce_op(bit cs, int row, int w);
    int base;
    base = act_cnt;
    ce_n = 0; cs_n = cs; ext_row = ROW_W'(row);
    wait_n(w);
    ce_n = 1; cs_n = 1;
    wait_n(RFD + A + PR + 2);
    chk(act_cnt == base + 1, cs ? "R4 ce-only count" : "R5 access count", act_cnt - base, 1);
    chk(int'(act_addr) == row, cs ? "R4 ext row" : "R5 ext row", int'(act_addr), row);
    chk(act_busy == cs, cs ? "R4 busy high" : "R5 busy low", int'(act_busy), int'(cs));
  endtask

  task automatic ignored_op(int row);
    int base;
    base = act_cnt;
    ce_n = 0; cs_n = 0; ext_row = ROW_W'(row);
    wait_n(2);
    rfsh_n = 0;
    wait_n(3);
    rfsh_n = 1;
    wait_n(2);
    ce_n = 1; cs_n = 1;
    wait_n(RFD + A + PR + 2);
    chk(act_cnt == base + 1, "R6 pulse under ce low ignored", act_cnt - base, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int base;
    seed_v = $urandom(32'd20240611);
    rst_n = 0; ce_n = 1; cs_n = 1; rfsh_n = 1; ext_row = '0;
    wait_n(3);
    // R1 reset state
    chk(row_act == 0, "R1 row_act reset", int'(row_act), 0);
    chk(busy == 0, "R1 busy reset", int'(busy), 0);
    chk(row_addr == 0, "R1 row_addr reset", int'(row_addr), 0);
    rst_n = 1;
    wait_n(RFD + 2);

    // R2 busy window and active length, first row is 0 (R1 counter)
    base = hi_cnt;
    rfsh_n = 0;
    wait_n(A + PR);
    chk(busy == 1, "R2 busy through precharge", int'(busy), 1);
    wait_n(1);
    chk(busy == 0, "R2 busy after precharge", int'(busy), 0);
    chk(hi_cnt - base == A, "R2 active cycles", hi_cnt - base, A);
    chk(int'(act_addr) == 0, "R1 counter starts at 0", int'(act_addr), 0);
    rfsh_n = 1;
    exp_ctr = 1;
    wait_n(3);

    // R11 row held while active
    ce_n = 0; cs_n = 0; ext_row = 9'd100;
    wait_n(2);
    ext_row = 9'd200;
    wait_n(1);
    chk(row_act == 1 && row_addr == 9'd100, "R11 row held", int'(row_addr), 100);
    ce_n = 1; cs_n = 1;
    wait_n(RFD + A + PR + 2);

    // R7 refresh delay after ce rise
    ce_n = 0; cs_n = 0; ext_row = 9'd5;
    wait_n(A + PR + 2);
    base = act_cnt;
    ce_n = 1; cs_n = 1; rfsh_n = 0;
    wait_n(RFD);
    chk(act_cnt == base, "R7 held before delay", act_cnt - base, 0);
    wait_n(1);
    chk(act_cnt == base + 1, "R7 start after delay", act_cnt - base, 1);
    chk(int'(act_addr) == exp_ctr, "R7 counter row", int'(act_addr), exp_ctr);
    exp_ctr = next_row(exp_ctr);
    rfsh_n = 1;
    wait_n(A + PR + 2);

    // R10 ce fall during refresh is dropped
    base = act_cnt;
    rfsh_n = 0;
    wait_n(1);
    ce_n = 0; cs_n = 1; ext_row = 9'd77;
    wait_n(3);
    ce_n = 1; rfsh_n = 1;
    wait_n(RFD + A + PR + 3);
    chk(act_cnt == base + 1, "R10 ce fall ignored", act_cnt - base, 1);
    chk(int'(act_addr) == exp_ctr, "R10 refresh row", int'(act_addr), exp_ctr);
    exp_ctr = next_row(exp_ctr);

    // R6 directed
    ignored_op(33);
    auto_op(2);

    // R3 wrap across 511 -> 0
    for (int i = 0; i < 515; i++) auto_op(1 + int'($urandom % 4));
    chk(exp_ctr == (3 + 1 + 515) % 512, "R3 wrap tracking", exp_ctr, (519) % 512);

    // R8 self-refresh: one auto plus three timer refreshes
    base = act_cnt;
    rfsh_n = 0;
    wait_n(T + 3 * P + P / 2);
    chk(busy == 1, "R8 busy in self-refresh", int'(busy), 1);
    chk(act_cnt == base + 4, "R8 refresh count", act_cnt - base, 4);
    chk(rise_cyc - prev_rise_cyc == P, "R8 interval", rise_cyc - prev_rise_cyc, P);
    chk(int'(act_addr) == (exp_ctr + 3) % 512, "R8 counter rows", int'(act_addr), (exp_ctr + 3) % 512);
    exp_ctr = (exp_ctr + 4) % 512;
    rfsh_n = 1;
    wait_n(RC);
    chk(busy == 1, "R9 recovery busy", int'(busy), 1);
    wait_n(1);
    chk(busy == 0, "R9 recovery end", int'(busy), 0);
    wait_n(RFD);

    // R9 exit on the same edge as the timer expiry: expiry dropped
    base = act_cnt;
    rfsh_n = 0;
    wait_n(T + P - 1);
    rfsh_n = 1;
    wait_n(RC);
    chk(busy == 1, "R9 collision recovery busy", int'(busy), 1);
    wait_n(1);
    chk(busy == 0, "R9 collision recovery end", int'(busy), 0);
    chk(act_cnt == base + 1, "R9 expiry on exit dropped", act_cnt - base, 1);
    exp_ctr = next_row(exp_ctr);
    wait_n(RFD);

    // R9 companion: release one cycle later, expiry wins
    base = act_cnt;
    rfsh_n = 0;
    wait_n(T + P);
    rfsh_n = 1;
    wait_n(RC + A + PR + 5);
    chk(act_cnt == base + 2, "R9 expiry before exit kept", act_cnt - base, 2);
    chk(int'(act_addr) == next_row(exp_ctr), "R9 second row", int'(act_addr), next_row(exp_ctr));
    exp_ctr = (exp_ctr + 2) % 512;
    chk(busy == 0, "R9 busy clear", int'(busy), 0);

    // random mix
    for (int i = 0; i < 150; i++) begin
      int k;
      k = int'($urandom % 4);
      case (k)
        0: auto_op(1 + int'($urandom % 40));
        1: ce_op(1'b1, int'($urandom % 512), 1 + int'($urandom % 6));
        2: ce_op(1'b0, int'($urandom % 512), 1 + int'($urandom % 6));
        default: ignored_op(int'($urandom % 512));
      endcase
    end
    auto_op(1);

    finish_run();
  end

endmodule